// File: doc/BRIEF.md
# Transmit Buffer Space Tracker

This block keeps a running account of the free space in the hardware buffer of one asynchronous transmit channel. Software posts buffers to the channel through an enqueue stream. For each accepted buffer, the tracker stores the buffer's byte count in a slot of a small size queue and subtracts that count from its space figure. The transmit engine consumes packets and reports how far it has got through an 8-bit read packet counter (`hw_rpc`). The tracker keeps its own read counter and steps it toward the hardware value one packet per clock. At each step it reads the stored size back out of the queue and credits it to the space figure.

Space is recovered packet by packet, by replaying the recorded sizes. It is never derived from byte addresses. A query names a channel. If that channel is the tracked one, the block answers with the current free space, or zero when the size queue cannot take another entry. Any other channel, or any channel before tracking starts, gets the all-ones value, which means unlimited. A separate flag, `space_valid`, says whether the space figure has caught up with the hardware counter.

The enqueue port uses a valid/ready handshake. A size is taken on a clock edge where both `enq_valid` and `enq_ready` are high. While `enq_ready` is low, the source must hold `enq_valid` and `enq_size` steady. Nothing is lost when the block holds off, because a size the block does not accept leaves no trace in its state.

Top module: `atx_fill_tracker`

## Requirements
- R1: After reset the block is not tracking. `enq_ready` is low, and every query returns space 16'hFFFF with `space_valid` high.
- R2: On a clock edge with `init_valid` high, the block does the following: it loads the space figure with `init_size`, sets both local counters to the zero-extended `hw_rpc`, starts tracking channel `init_ch`, and drops any enqueue. `enq_ready` is low in every cycle where `init_valid` is high.
- R3: `enq_ready` is high only when the block is tracking, `init_valid` is low and fewer than 255 packets are outstanding. An accepted size is written to queue slot `wr_pc[7:0]` and subtracted from the space figure, and the write counter then goes up by one.
- R4: For a query of the tracked channel with fewer than 255 packets outstanding, `space` equals the space figure, modulo 2^16.
- R5: When the write counter minus the read counter, taken modulo 2^16, is at least 255, the block reports `space` as 0 for the tracked channel and does not accept an enqueue. A size held on the port during that time changes nothing.
- R6: A query whose `query_ch` differs from the tracked channel returns 16'hFFFF with `space_valid` high.
- R7: In each clock where the low 8 bits of the local read counter differ from `hw_rpc`, the local read counter advances by exactly one and the size stored in that slot is added back to the space figure. The counter never advances by more than one per clock. While the two values differ, `space_valid` is low for the tracked channel.
- R8: Once `hw_rpc` has reached every enqueued packet and the counters agree again, `space` equals the most recent `init_size`.
- R9: An enqueue and a recovery step in the same clock both take effect: the space figure changes by the recovered size minus the enqueued size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_valid | input | 1 | Start or restart tracking |
| init_size | input | 16 | Buffer size loaded as free space on init |
| init_ch | input | 6 | Channel to track, captured on init |
| hw_rpc | input | 8 | Hardware read packet counter |
| enq_valid | input | 1 | Enqueue stream valid |
| enq_ready | output | 1 | Enqueue stream ready |
| enq_size | input | 16 | Byte count of the posted buffer |
| query_ch | input | 6 | Channel whose space is asked for |
| space | output | 16 | Free space, 0 when the queue is full, 16'hFFFF when the channel is not tracked |
| space_valid | output | 1 | Space figure has caught up with `hw_rpc` |

## Verification
The hardest state to reach from the ports is a full size queue: 255 outstanding packets, with the slot indices wrapping past 255 and a large backlog of recovery to work through. The stimulus first starts tracking at a nonzero hardware counter and holds the consumer still. It then pushes 255 buffers of varying sizes and keeps a further size waiting at the port while the queue is full. After that, `hw_rpc` jumps ahead by ten packets at once, and finally by the whole remaining backlog. This exercises several cycles of recovery at one packet per clock while `space_valid` is low, and ends with the return to the initial size.

// File: rtl/atx_fill_pkg.sv
package atx_fill_pkg;
  typedef enum logic [1:0] {
    SRC_UNLIMITED = 2'd0,
    SRC_FULL      = 2'd1,
    SRC_REST      = 2'd2
  } space_src_e;
endpackage

// File: rtl/atx_size_queue.sv
module atx_size_queue #(
  parameter int SLOT_W = 8,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [SIZE_W-1:0] rd_size
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [SIZE_W-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot] <= wr_size;
  end

  assign rd_size = mem[rd_slot];
endmodule

// File: rtl/atx_space_sel.sv
module atx_space_sel
  import atx_fill_pkg::*;
#(
  parameter int SLOT_W = 8,
  parameter int SIZE_W = 16,
  parameter int CH_W   = 6
) (
  input  logic              tracking,
  input  logic [CH_W-1:0]   trk_ch,
  input  logic [CH_W-1:0]   query_ch,
  input  logic              full,
  input  logic [SIZE_W-1:0] rest,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [SLOT_W-1:0] hw_rpc,
  output logic [SIZE_W-1:0] space,
  output logic              space_valid
);
  space_src_e src;

  always_comb begin
    if (!tracking || (query_ch != trk_ch)) src = SRC_UNLIMITED;
    else if (full)                         src = SRC_FULL;
    else                                   src = SRC_REST;
  end

  always_comb begin
    case (src)
      SRC_UNLIMITED: space = '1;
      SRC_FULL:      space = '0;
      default:       space = rest;
    endcase
    space_valid = (src == SRC_UNLIMITED) || (rd_slot == hw_rpc);
  end
endmodule

// File: rtl/atx_fill_tracker.sv
module atx_fill_tracker #(
  parameter int SLOT_W = 8,
  parameter int SIZE_W = 16,
  parameter int PC_W   = 16,
  parameter int CH_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_valid,
  input  logic [SIZE_W-1:0] init_size,
  input  logic [CH_W-1:0]   init_ch,
  input  logic [SLOT_W-1:0] hw_rpc,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [SIZE_W-1:0] enq_size,
  input  logic [CH_W-1:0]   query_ch,
  output logic [SIZE_W-1:0] space,
  output logic              space_valid
);
  localparam int SLOTS = 1 << SLOT_W;
  localparam logic [PC_W-1:0] LIMIT = PC_W'(SLOTS - 1);

  logic [PC_W-1:0]   wr_pc, rd_pc, outstanding;
  logic [SIZE_W-1:0] rest, rec_size, enq_amt, rec_amt;
  logic              tracking, full, catch_up, enq_fire;
  logic [CH_W-1:0]   trk_ch;
  logic [SLOT_W-1:0] rd_slot, wr_slot;

  assign rd_slot     = rd_pc[SLOT_W-1:0];
  assign wr_slot     = wr_pc[SLOT_W-1:0];
  assign outstanding = wr_pc - rd_pc;
  assign full        = outstanding >= LIMIT;
  assign catch_up    = tracking && !init_valid && (rd_slot != hw_rpc);
  assign enq_ready   = tracking && !init_valid && !full;
  assign enq_fire    = enq_valid && enq_ready;
  assign enq_amt     = enq_fire ? enq_size : '0;
  assign rec_amt     = catch_up ? rec_size : '0;

  atx_size_queue #(.SLOT_W(SLOT_W), .SIZE_W(SIZE_W)) u_queue (
    .clk     (clk),
    .wr_en   (enq_fire),
    .wr_slot (wr_slot),
    .wr_size (enq_size),
    .rd_slot (rd_slot),
    .rd_size (rec_size)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tracking <= 1'b0;
      trk_ch   <= '0;
      rest     <= '0;
      wr_pc    <= '0;
      rd_pc    <= '0;
    end else if (init_valid) begin
      tracking <= 1'b1;
      trk_ch   <= init_ch;
      rest     <= init_size;
      wr_pc    <= PC_W'(hw_rpc);
      rd_pc    <= PC_W'(hw_rpc);
    end else if (tracking) begin
      rest  <= rest - enq_amt + rec_amt;
      wr_pc <= wr_pc + PC_W'(enq_fire);
      rd_pc <= rd_pc + PC_W'(catch_up);
    end
  end

  atx_space_sel #(.SLOT_W(SLOT_W), .SIZE_W(SIZE_W), .CH_W(CH_W)) u_sel (
    .tracking    (tracking),
    .trk_ch      (trk_ch),
    .query_ch    (query_ch),
    .full        (full),
    .rest        (rest),
    .rd_slot     (rd_slot),
    .hw_rpc      (hw_rpc),
    .space       (space),
    .space_valid (space_valid)
  );
endmodule

// File: rtl/atx_fill_tracker_chk.sv
module atx_fill_tracker_chk #(
  parameter int SLOT_W = 8,
  parameter int SIZE_W = 16,
  parameter int PC_W   = 16,
  parameter int CH_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_valid,
  input logic [SIZE_W-1:0] init_size,
  input logic [SLOT_W-1:0] hw_rpc,
  input logic              enq_valid,
  input logic              enq_ready,
  input logic [CH_W-1:0]   query_ch,
  input logic [SIZE_W-1:0] space,
  input logic              space_valid,
  input logic              tracking,
  input logic [CH_W-1:0]   trk_ch,
  input logic [SIZE_W-1:0] rest,
  input logic [PC_W-1:0]   wr_pc,
  input logic [PC_W-1:0]   rd_pc
);
  localparam logic [PC_W-1:0] LIMIT = PC_W'((1 << SLOT_W) - 1);
  logic [PC_W-1:0] pending;
  assign pending = wr_pc - rd_pc;

  p_init_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_valid |=> (tracking && rest == $past(init_size) && wr_pc == rd_pc));

  p_init_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_valid |-> !enq_ready);

  p_enq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && enq_ready) |=> (wr_pc == $past(wr_pc) + PC_W'(1)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && pending >= LIMIT) |-> !enq_ready);

  p_full_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && query_ch == trk_ch && pending >= LIMIT) |-> (space == '0));

  p_foreign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tracking || query_ch != trk_ch) |-> (space == '1 && space_valid));

  p_one_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && !init_valid) |=>
      (rd_pc == $past(rd_pc) || rd_pc == $past(rd_pc) + PC_W'(1)));

  p_valid_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && query_ch == trk_ch && rd_pc[SLOT_W-1:0] != hw_rpc) |-> !space_valid);
endmodule

bind atx_fill_tracker atx_fill_tracker_chk #(
  .SLOT_W(SLOT_W), .SIZE_W(SIZE_W), .PC_W(PC_W), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_size(init_size),
  .hw_rpc(hw_rpc), .enq_valid(enq_valid), .enq_ready(enq_ready),
  .query_ch(query_ch), .space(space), .space_valid(space_valid),
  .tracking(tracking), .trk_ch(trk_ch), .rest(rest), .wr_pc(wr_pc), .rd_pc(rd_pc)
);

// File: tb/sim_atx_fill_tracker.sv
module sim_atx_fill_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_valid = 1'b0;
  logic [15:0] init_size = '0;
  logic [5:0]  init_ch = '0;
  logic [7:0]  hw_rpc = '0;
  logic        enq_valid = 1'b0;
  logic        enq_ready;
  logic [15:0] enq_size = '0;
  logic [5:0]  query_ch = '0;
  logic [15:0] space;
  logic        space_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  bit          m_trk = 1'b0;
  logic [5:0]  m_ch = '0;
  logic [15:0] m_rest = '0, m_wr = '0, m_rd = '0;
  logic [15:0] m_q [256];
  logic [15:0] hw = '0;

  always #4 clk = ~clk;

  atx_fill_tracker u0 (
    .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_size(init_size),
    .init_ch(init_ch), .hw_rpc(hw_rpc), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_size(enq_size), .query_ch(query_ch), .space(space), .space_valid(space_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_full();
    logic [15:0] d;
    d = m_wr - m_rd;
    return d >= 16'd255;
  endfunction

  function automatic bit m_ready();
    return m_trk && !init_valid && !m_full();
  endfunction

  task automatic compare();
    logic [15:0] es;
    bit ev;
    string tg;
    bit foreign;
    foreign = !m_trk || (query_ch != m_ch);
    if (foreign) begin es = 16'hFFFF; ev = 1'b1; end
    else begin
      es = m_full() ? 16'h0 : m_rest;
      ev = (m_rd[7:0] == hw_rpc);
    end
    if (!m_trk) tg = "R1";
    else if (foreign) tg = "R6";
    else if (m_full()) tg = "R5";
    else if (!ev) tg = "R7";
    else tg = "R4";
    chk(space == es, tg, space, es);
    chk(space_valid == ev, "R7 valid", space_valid, ev);
    chk(enq_ready == m_ready(), "R3 ready", enq_ready, m_ready());
  endtask

  task automatic model_next();
    bit acc, stp;
    logic [15:0] add;
    if (init_valid) begin
      m_trk = 1'b1; m_ch = init_ch; m_rest = init_size;
      m_wr = {8'h0, hw_rpc}; m_rd = {8'h0, hw_rpc};
    end else if (m_trk) begin
      acc = enq_valid && m_ready();
      stp = (m_rd[7:0] != hw_rpc);
      add = stp ? m_q[m_rd[7:0]] : 16'h0;
      if (acc) begin
        m_q[m_wr[7:0]] = enq_size;
        m_rest = m_rest - enq_size;
        m_wr = m_wr + 16'd1;
      end
      m_rest = m_rest + add;
      if (stp) m_rd = m_rd + 16'd1;
    end
  endtask

  // inputs are set in the low phase; compare, advance model, clock
  task automatic tick();
    hw_rpc = hw[7:0];
    #1;
    if (rst_n) compare();
    model_next();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [15:0] sz);
    bit acc;
    enq_valid = 1'b1; enq_size = sz;
    acc = 1'b0;
    while (!acc) begin
      hw_rpc = hw[7:0];
      #1;
      acc = m_ready();
      #0;
      tick();
    end
    enq_valid = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    query_ch = 6'd3;
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state seen at the ports
    chk(space == 16'hFFFF, "R1 space", space, 16'hFFFF);
    chk(enq_ready == 1'b0, "R1 ready", enq_ready, 0);
    chk(space_valid == 1'b1, "R1 valid", space_valid, 1);
    tick(); tick();

    // R2: init at nonzero hw counter, simultaneous enqueue dropped
    hw = 16'd5;
    init_valid = 1'b1; init_size = 16'd1000; init_ch = 6'd3;
    enq_valid = 1'b1; enq_size = 16'd7;
    tick();
    init_valid = 1'b0; enq_valid = 1'b0;
    #1;
    chk(space == 16'd1000, "R2 init space", space, 1000);
    tick();

    send(16'd100); send(16'd200); send(16'd50);
    tick();
    chk(space == 16'd650, "R3 after enqueues", space, 650);
    hw = hw + 16'd1; tick();
    hw = hw + 16'd1; tick(); tick();
    // R9: enqueue and recovery in the same clock
    hw = hw + 16'd1;
    send(16'd30);
    #1;
    chk(space == 16'd970, "R9 combined step", space, 970);
    tick();
    query_ch = 6'd4; tick();
    query_ch = 6'd3;
    hw = m_wr; tick();
    #1;
    chk(space == 16'd1000, "R8 restored", space, 1000);
    tick();

    // R5: fill the queue, slots wrap past 255
    init_valid = 1'b1; init_size = 16'd4000; tick();
    init_valid = 1'b0;
    for (int i = 0; i < 255; i++) send(16'(i % 7 + 1));
    enq_valid = 1'b1; enq_size = 16'd99;
    repeat (5) tick();
    #1;
    chk(space == 16'd0, "R5 full space", space, 0);
    chk(enq_ready == 1'b0, "R5 full ready", enq_ready, 0);
    enq_valid = 1'b0;
    // R7: jump of ten, recovered one per clock
    hw = hw + 16'd10;
    for (int i = 0; i < 10; i++) tick();
    #1;
    chk(space_valid == 1'b1, "R7 caught up", space_valid, 1);
    hw = m_wr;
    for (int i = 0; i < 300 && !(space_valid && m_rd == m_wr); i++) tick();
    #1;
    chk(space == 16'd4000, "R8 restored full", space, 4000);
    tick();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule